// File: doc/BRIEF.md
# Set-Associative Pseudo-LRU Victim Controller

This block keeps the replacement state of an 8-way set-associative cache with 128 sets. For every set it holds one valid flag per way and a binary pseudo-LRU tree. Every cycle it names the way that a fill into the addressed set should replace. The cache pipeline drives an access strobe with a set index and the way that was hit or filled, so that the block can age that way. It can also invalidate a single line, or clear the whole cache with a one-cycle flash pulse.

In normal mode the victim is the lowest-numbered invalid way. Only when every way of the set is valid does the pseudo-LRU tree decide. A flush-assist mode bit makes selection ignore the valid flags and follow the tree alone. A software flush loop that fills eight distinct addresses into one set, each one replacing the way currently named, then evicts every way exactly once. Tag and data storage are not part of this block.

Top module: `plru_ctrl`

## Requirements
- R1: After a cycle with `rst` high, every set has no valid way and its tree names way 0. `victim_way` reads 0 for any set in either mode.
- R2: A cycle with `flash_inv` high puts every set into the state of R1 from the next cycle on.
- R3: When `flash_inv` is high in the same cycle as an access or a line invalidate, the flash result alone is kept, and the access leaves no trace in valid flags or tree.
- R4: With `flush_assist` low and at least one invalid way in the addressed set, `victim_way` is the lowest-numbered invalid way.
- R5: With `flush_assist` low and all eight ways valid, `victim_way` is the way named by the set's tree.
- R6: Tree encoding: node 0 is the root, node n has children 2n+1 (lower half of its ways) and 2n+2 (upper half), and a node bit of 0 points to the lower half. An access to way w sets every node on w's path to point away from w. Example: after fills of ways 0..7 in order the tree names way 0, and a hit on way 0 then makes it name way 4.
- R7: With `flush_assist` high, `victim_way` follows the tree regardless of valid flags. From the R1 state, eight fills to one set, each to the named way, replace ways 0,4,2,6,1,5,3,7 in that order.
- R8: An access with `acc_fill` high marks the way valid. An access with `acc_fill` low (a hit) updates only the tree.
- R9: A line invalidate clears the valid flag of `inv_way` in set `inv_set` and leaves that set's tree unchanged. It overrides a fill to the same line in the same cycle.
- R10: Accesses and invalidates change only the set they address.
- R11: `victim_way` depends combinationally on `acc_set` and the stored state. State changes show on the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe (hit or fill) |
| acc_fill | input | 1 | 1 = access is a fill, 0 = hit |
| acc_set | input | 7 | Addressed set, also selects the victim shown |
| acc_way | input | 3 | Way that was hit or filled |
| inv_req | input | 1 | Single-line invalidate strobe |
| inv_set | input | 7 | Set of the line to invalidate |
| inv_way | input | 3 | Way of the line to invalidate |
| flash_inv | input | 1 | Clear all sets in one cycle |
| flush_assist | input | 1 | Victim follows the tree only |
| victim_way | output | 3 | Way to replace in `acc_set` |

## Verification
Fills in ascending order first exercise the lowest-invalid rule. They then fill the set completely, which separates the invalid-way path from the tree path. Hits on chosen ways then show that the tree points away from the touched way without marking it valid. Probing the same state with flush-assist on and off separates tree-only choice from valid-first choice. The eight-fill flush sweep from a cleared set confirms that the tree visits every way once. Flash pulses and line invalidates that coincide with fills, plus probes of an untouched second set, check priority and set isolation.

// File: rtl/plru_pkg.sv
package plru_pkg;

    localparam int DEF_SETS = 128;
    localparam int DEF_WAYS = 8;

    // per-set write controls decoded from the request strobes
    typedef struct packed {
        logic wipe;     // flash or reset: back to the cleared state
        logic touch;    // load the updated tree
        logic mark;     // set the valid flag of the accessed way
        logic drop;     // clear the valid flag of the invalidated way
    } set_ctl_t;

    function automatic set_ctl_t decode_ctl(
        input logic wipe,
        input logic acc_here,
        input logic is_fill,
        input logic inv_here
    );
        set_ctl_t c;
        c.wipe  = wipe;
        c.touch = acc_here && !wipe;
        c.mark  = acc_here && is_fill && !wipe;
        c.drop  = inv_here && !wipe;
        return c;
    endfunction

endpackage

// File: rtl/plru_tree_next.sv
module plru_tree_next #(
    parameter int WAYS = plru_pkg::DEF_WAYS,
    localparam int LVLS = $clog2(WAYS),
    localparam int NODES = WAYS - 1
) (
    input  logic [NODES-1:0] tree_q,
    input  logic [LVLS-1:0]  way,
    output logic [NODES-1:0] tree_d
);

    // walk the path of 'way' from the root and point each node away from it
    always_comb begin
        int node;
        tree_d = tree_q;
        for (int l = 0; l < LVLS; l++) begin
            node = (1 << l) - 1 + int'(way >> (LVLS - l));
            tree_d[node] = ~way[LVLS-1-l];
        end
    end

endmodule

// File: rtl/plru_victim_sel.sv
module plru_victim_sel #(
    parameter int WAYS = plru_pkg::DEF_WAYS,
    localparam int LVLS = $clog2(WAYS),
    localparam int NODES = WAYS - 1
) (
    input  logic [WAYS-1:0]  valid,
    input  logic [NODES-1:0] tree,
    input  logic             assist,
    output logic [LVLS-1:0]  victim
);

    logic [LVLS-1:0] tree_pick;
    logic [LVLS-1:0] free_pick;
    logic            any_free;

    // follow the node bits from the root down to a leaf
    always_comb begin
        int  node;
        logic b;
        node = 0;
        tree_pick = '0;
        for (int l = 0; l < LVLS; l++) begin
            b = tree[node];
            tree_pick[LVLS-1-l] = b;
            node = 2 * node + 1 + int'(b);
        end
    end

    // descending scan: the last hit is the lowest free way
    always_comb begin
        free_pick = '0;
        any_free  = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                free_pick = LVLS'(w);
                any_free  = 1'b1;
            end
        end
    end

    assign victim = (assist || !any_free) ? tree_pick : free_pick;

endmodule

// File: rtl/plru_set_store.sv
module plru_set_store
    import plru_pkg::*;
#(
    parameter int SETS = plru_pkg::DEF_SETS,
    parameter int WAYS = plru_pkg::DEF_WAYS,
    localparam int SET_W = $clog2(SETS),
    localparam int LVLS = $clog2(WAYS),
    localparam int NODES = WAYS - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flash_inv,
    input  logic             acc_valid,
    input  logic             acc_fill,
    input  logic [SET_W-1:0] acc_set,
    input  logic [LVLS-1:0]  acc_way,
    input  logic [NODES-1:0] tree_upd,
    input  logic             inv_req,
    input  logic [SET_W-1:0] inv_set,
    input  logic [LVLS-1:0]  inv_way,
    output logic [WAYS-1:0]  rd_valid,
    output logic [NODES-1:0] rd_tree
);

    logic [WAYS-1:0]  vld_arr  [SETS];
    logic [NODES-1:0] tree_arr [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        set_ctl_t         ctl;
        logic [WAYS-1:0]  vq;
        logic [WAYS-1:0]  vn;
        logic [NODES-1:0] tq;

        assign ctl = decode_ctl(rst || flash_inv,
                                acc_valid && (acc_set == SET_W'(s)),
                                acc_fill,
                                inv_req && (inv_set == SET_W'(s)));

        // invalidate applied after the fill so it wins on the same line
        always_comb begin
            vn = vq;
            if (ctl.mark) vn[acc_way] = 1'b1;
            if (ctl.drop) vn[inv_way] = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (ctl.wipe) begin
                vq <= '0;
                tq <= '0;
            end else begin
                vq <= vn;
                if (ctl.touch) tq <= tree_upd;
            end
        end

        assign vld_arr[s]  = vq;
        assign tree_arr[s] = tq;
    end

    assign rd_valid = vld_arr[acc_set];
    assign rd_tree  = tree_arr[acc_set];

    // R1: reset leaves every set cleared
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (rd_valid == '0 && rd_tree == '0));

    // R2: flash leaves every set cleared
    a_r2_flash_clear: assert property (@(posedge clk) disable iff (rst)
        flash_inv |=> (rd_valid == '0 && rd_tree == '0));

    // R9: the invalidated line is no longer valid
    a_r9_line_dropped: assert property (@(posedge clk) disable iff (rst)
        inv_req |=> !vld_arr[$past(inv_set)][$past(inv_way)]);

    // R9: a lone invalidate keeps the tree of its set
    a_r9_tree_kept: assert property (@(posedge clk) disable iff (rst)
        (inv_req && !acc_valid && !flash_inv)
        |=> tree_arr[$past(inv_set)] == $past(tree_arr[inv_set]));

    // R8: a fill not cancelled by flash or same-line invalidate marks valid
    a_r8_fill_marks: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_fill && !flash_inv &&
         !(inv_req && inv_set == acc_set && inv_way == acc_way))
        |=> vld_arr[$past(acc_set)][$past(acc_way)]);

    // R8: a hit never changes valid flags of its set
    a_r8_hit_keeps_valid: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_fill && !flash_inv && !inv_req)
        |=> vld_arr[$past(acc_set)] == $past(vld_arr[acc_set]));

endmodule

// File: rtl/plru_ctrl.sv
module plru_ctrl #(
    parameter int SETS = plru_pkg::DEF_SETS,
    parameter int WAYS = plru_pkg::DEF_WAYS,
    localparam int SET_W = $clog2(SETS),
    localparam int LVLS = $clog2(WAYS),
    localparam int NODES = WAYS - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic             acc_fill,
    input  logic [SET_W-1:0] acc_set,
    input  logic [LVLS-1:0]  acc_way,
    input  logic             inv_req,
    input  logic [SET_W-1:0] inv_set,
    input  logic [LVLS-1:0]  inv_way,
    input  logic             flash_inv,
    input  logic             flush_assist,
    output logic [LVLS-1:0]  victim_way
);

    logic [WAYS-1:0]  rd_valid;
    logic [NODES-1:0] rd_tree;
    logic [NODES-1:0] tree_upd;

    plru_tree_next #(.WAYS(WAYS)) u_next (
        .tree_q (rd_tree),
        .way    (acc_way),
        .tree_d (tree_upd)
    );

    plru_set_store #(.SETS(SETS), .WAYS(WAYS)) u_store (
        .clk       (clk),
        .rst       (rst),
        .flash_inv (flash_inv),
        .acc_valid (acc_valid),
        .acc_fill  (acc_fill),
        .acc_set   (acc_set),
        .acc_way   (acc_way),
        .tree_upd  (tree_upd),
        .inv_req   (inv_req),
        .inv_set   (inv_set),
        .inv_way   (inv_way),
        .rd_valid  (rd_valid),
        .rd_tree   (rd_tree)
    );

    plru_victim_sel #(.WAYS(WAYS)) u_sel (
        .valid  (rd_valid),
        .tree   (rd_tree),
        .assist (flush_assist),
        .victim (victim_way)
    );

    // R4: in normal mode a set with free ways never names a valid way
    a_r4_free_first: assert property (@(posedge clk) disable iff (rst)
        (!flush_assist && rd_valid != '1) |-> !rd_valid[victim_way]);

    // R6: the way just touched is not what the tree names next
    a_r6_points_away: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !flash_inv && flush_assist && $stable(acc_set))
        |-> ##1 (!$stable(acc_set) || !flush_assist ||
                 victim_way != $past(acc_way)));

endmodule

// File: tb/plru_ctrl_test.sv
module plru_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       acc_valid, acc_fill, inv_req, flash_inv, flush_assist;
    logic [6:0] acc_set, inv_set;
    logic [2:0] acc_way, inv_way;
    logic [2:0] victim_way;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    plru_ctrl uut (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_fill(acc_fill),
        .acc_set(acc_set), .acc_way(acc_way),
        .inv_req(inv_req), .inv_set(inv_set), .inv_way(inv_way),
        .flash_inv(flash_inv), .flush_assist(flush_assist),
        .victim_way(victim_way)
    );

    typedef struct packed {
        logic       av;
        logic       fill;
        logic [6:0] aset;
        logic [2:0] aw;
        logic       inv;
        logic [6:0] iset;
        logic [2:0] iw;
        logic       fl;
        logic [6:0] pset;
        logic       pa;
        logic [2:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 32;
    // av fill aset aw | inv iset iw | fl | probe set, probe assist | expected | req
    localparam vec_t TBL [NV] = '{
        '{1'b1,1'b1,7'd5,3'd0, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b0, 3'd1, 4'd8},  // R8 R4
        '{1'b0,1'b0,7'd0,3'd0, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b1, 3'd4, 4'd7},  // R7
        '{1'b1,1'b1,7'd5,3'd1, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b0, 3'd2, 4'd4},  // R4
        '{1'b1,1'b1,7'd5,3'd2, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b0, 3'd3, 4'd4},
        '{1'b1,1'b1,7'd5,3'd3, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b0, 3'd4, 4'd4},
        '{1'b1,1'b1,7'd5,3'd4, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b0, 3'd5, 4'd4},
        '{1'b1,1'b1,7'd5,3'd5, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b0, 3'd6, 4'd4},
        '{1'b1,1'b1,7'd5,3'd6, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b0, 3'd7, 4'd4},
        '{1'b1,1'b1,7'd5,3'd7, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b0, 3'd0, 4'd5},  // R5
        '{1'b1,1'b0,7'd5,3'd0, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b0, 3'd4, 4'd6},  // R6
        '{1'b0,1'b0,7'd0,3'd0, 1'b0,7'd0,3'd0, 1'b0, 7'd9,1'b0, 3'd0, 4'd10}, // R10
        '{1'b1,1'b1,7'd9,3'd0, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b0, 3'd4, 4'd10}, // R10
        '{1'b0,1'b0,7'd0,3'd0, 1'b1,7'd5,3'd5, 1'b0, 7'd5,1'b0, 3'd5, 4'd9},  // R9
        '{1'b0,1'b0,7'd0,3'd0, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b1, 3'd4, 4'd9},  // R9 tree kept
        '{1'b1,1'b0,7'd5,3'd4, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b1, 3'd2, 4'd6},  // R6
        '{1'b0,1'b0,7'd0,3'd0, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b0, 3'd5, 4'd8},  // R8 hit no valid
        '{1'b1,1'b1,7'd5,3'd5, 1'b1,7'd5,3'd5, 1'b0, 7'd5,1'b0, 3'd5, 4'd9},  // R9 beats fill
        '{1'b0,1'b0,7'd0,3'd0, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b1, 3'd2, 4'd6},  // R6
        '{1'b1,1'b1,7'd5,3'd5, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b0, 3'd2, 4'd5},  // R5
        '{1'b1,1'b1,7'd5,3'd3, 1'b1,7'd5,3'd1, 1'b1, 7'd5,1'b0, 3'd0, 4'd3},  // R3
        '{1'b0,1'b0,7'd0,3'd0, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b1, 3'd0, 4'd3},  // R3
        '{1'b1,1'b1,7'd5,3'd0, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b0, 3'd1, 4'd2},  // R2
        '{1'b0,1'b0,7'd0,3'd0, 1'b0,7'd0,3'd0, 1'b0, 7'd9,1'b0, 3'd0, 4'd2},  // R2 other set
        '{1'b0,1'b0,7'd0,3'd0, 1'b0,7'd0,3'd0, 1'b1, 7'd5,1'b1, 3'd0, 4'd2},  // R2
        '{1'b1,1'b1,7'd5,3'd0, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b1, 3'd4, 4'd7},  // R7 sweep
        '{1'b1,1'b1,7'd5,3'd4, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b1, 3'd2, 4'd7},
        '{1'b1,1'b1,7'd5,3'd2, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b1, 3'd6, 4'd7},
        '{1'b1,1'b1,7'd5,3'd6, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b1, 3'd1, 4'd7},
        '{1'b1,1'b1,7'd5,3'd1, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b1, 3'd5, 4'd7},
        '{1'b1,1'b1,7'd5,3'd5, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b1, 3'd3, 4'd7},
        '{1'b1,1'b1,7'd5,3'd3, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b1, 3'd7, 4'd7},
        '{1'b1,1'b1,7'd5,3'd7, 1'b0,7'd0,3'd0, 1'b0, 7'd5,1'b1, 3'd0, 4'd7}
    };

    task automatic check(input int req, input logic [2:0] exp, input string what);
        total++;
        if (victim_way !== exp) begin
            bad++;
            $display("FAIL R%0d %s: victim_way=%0d expected=%0d", req, what, victim_way, exp);
        end
    endtask

    task automatic idle(input logic [6:0] pset, input logic pa);
        acc_valid = 1'b0; acc_fill = 1'b0; acc_set = pset; acc_way = '0;
        inv_req = 1'b0; inv_set = '0; inv_way = '0;
        flash_inv = 1'b0; flush_assist = pa;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        idle(7'd5, 1'b0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state in both modes and at another set
        check(1, 3'd0, "reset normal");
        flush_assist = 1'b1; #1;
        check(1, 3'd0, "reset assist");
        acc_set = 7'd127; #1;
        check(1, 3'd0, "reset last set");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            acc_valid = TBL[i].av; acc_fill = TBL[i].fill;
            acc_set = TBL[i].aset; acc_way = TBL[i].aw;
            inv_req = TBL[i].inv; inv_set = TBL[i].iset; inv_way = TBL[i].iw;
            flash_inv = TBL[i].fl; flush_assist = 1'b0;
            @(negedge clk);
            idle(TBL[i].pset, TBL[i].pa);
            #1;
            check(int'(TBL[i].req), TBL[i].exp, $sformatf("vector %0d", i));
        end

        // R11: victim follows acc_set with no clock edge
        @(negedge clk);
        idle(7'd9, 1'b0);
        acc_valid = 1'b1; acc_fill = 1'b1; acc_way = 3'd0;
        #1;
        check(11, 3'd0, "before edge");
        @(negedge clk);
        idle(7'd9, 1'b0); #1;
        check(11, 3'd1, "after edge");
        acc_set = 7'd5; #1;
        check(11, 3'd0, "set switch comb");
        acc_set = 7'd9; #1;
        check(11, 3'd1, "set switch back");

        // R1: reset again after activity clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; idle(7'd9, 1'b0); #1;
        check(1, 3'd0, "second reset");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule